// File: doc/BRIEF.md
# Micro-op Decode Steering Unit

This unit sits between an instruction classifier and the scheduler's micro-op queue. Each cycle it sees a window of up to three classified instructions, oldest in lane 0. Each instruction carries a micro-op count and, for short instructions, its micro-op payloads. The unit builds a decode group and writes the group's micro-ops, in program order, into a six-entry queue. A downstream consumer drains that queue up to three entries per cycle.

Steering is asymmetric. Only the oldest lane may hold an instruction with more than one micro-op. An oldest-lane instruction of one to four micro-ops goes to the complex slot. The two younger lanes act as simple slots and take only single-micro-op instructions that directly follow it. An oldest-lane instruction of five or more micro-ops is accepted on its own and handed to a sequencer. From the next cycle, the sequencer reads its micro-ops from a computed ROM, up to four per cycle. A flush input empties the queue and aborts the sequencer.

The window protocol works as follows. The producer presents contiguous valid lanes starting at lane 0. `inReady` marks, in the same cycle, the lanes consumed at the next clock edge. Unconsumed instructions are presented again in the next cycle, shifted down to the oldest lanes.

Top module: `uop_steer_top`

## Requirements
- R1: After reset the queue is empty (`outValid` = 000), and `inReady` is 000 while no lane is valid.
- R2: A lane is consumed only if every older lane is consumed in the same cycle. `inReady[i]` is high exactly for the lanes consumed at the coming edge. A valid count is 1 to 15.
- R3: Lanes 1 and 2 are consumed only if their count is 1 and lane 0 has a count of at most 4.
- R4: For a lane-0 count of 1 to 4, the queue receives `headPayload[0]` up to `headPayload[count-1]`, then `tailPayload[0]` if lane 1 is taken, then `tailPayload[1]` if lane 2 is taken, in that order.
- R5: The group's micro-op total is compared with the free space, where free space is 6 minus the occupancy at the start of the cycle. A group that does not fit consumes no lane at all.
- R6: A lane-0 count of 5 or more is consumed alone. From the next cycle, the sequencer writes that many ROM micro-ops (steps 0 up to count-1) in chunks of min(4, remaining). A chunk is written only when the free space is at least its size. No lane is consumed from acceptance until the last chunk is written.
- R7: ROM micro-op number s of opcode op has bits [117:112] = 101101, bits [11:4] = op, bits [3:0] = s, and all other bits zero.
- R8: `outValid[i]` is high when queue entry i exists, with the oldest entry in lane 0. The popped entries are the leading lanes with both `outValid` and `outReady` high, at most 3 per cycle. A written micro-op is visible from the cycle after its group is consumed. The oldest entry is held stable until it is popped.
- R9: A group of 6 micro-ops (4 + 1 + 1) is accepted in one cycle into an empty queue. A full queue (6 entries) consumes nothing.
- R10: While `flush` is high, no lane is consumed. In the next cycle the queue is empty and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue and aborts the sequencer |
| inValid | input | 3 | Lane valid bits, contiguous from lane 0 |
| inReady | output | 3 | Lanes consumed at the coming edge |
| inCount | input | 3x4 | Micro-op count per lane |
| inOpcode | input | 8 | Opcode of lane 0, selects the ROM sequence |
| headPayload | input | 4x118 | Micro-op payloads of lane 0 |
| tailPayload | input | 2x118 | Single micro-op of lanes 1 and 2 |
| outValid | output | 3 | Queue entry present, oldest in lane 0 |
| outReady | input | 3 | Consumer accepts the lane |
| outUop | output | 3x118 | Oldest three queue entries |

## Verification
The bench targets the steering boundaries. A multi-micro-op instruction in a younger lane must not be taken; a design that got this wrong would mark lane 1 ready and reorder the stream. It also checks that a group larger than the remaining space consumes nothing. A design that took a partial group, or that counted this cycle's pops as free space, would raise `inReady` one cycle early. For a ten-micro-op sequence the bench checks the exact ROM words and their order. It also checks that the window stays blocked for the four cycles the sequencer needs, with chunks of 4, 4 and 2 under back-pressure. A flush in the middle of a sequence must leave an empty queue and an idle sequencer. A design that kept the sequencer running would emit stale ROM words ahead of the next instruction.

// File: rtl/uop_steer_pkg.sv
package uop_steer_pkg;
  localparam int LANES  = 3;
  localparam int CNT_W  = 4;
  localparam int PUSH_W = 4;
  localparam logic [5:0] ROM_TAG = 6'b101101;

  typedef struct packed {
    logic [LANES-1:0]  take;
    logic [PUSH_W-1:0] pushCnt;
    logic              seqLatch;
    logic              seqEmit;
    logic [CNT_W-1:0]  seqStep;
    logic              doFlush;
  } steerStrobe_t;
endpackage

// File: rtl/uop_seq_rom.sv
module uop_seq_rom
  import uop_steer_pkg::*;
#(
  parameter int UOP_W    = 118,
  parameter int OPC_W    = 8,
  parameter int SEQ_RATE = 4
) (
  input  logic [OPC_W-1:0]                  opcode,
  input  logic [CNT_W-1:0]                  baseStep,
  output logic [SEQ_RATE-1:0][UOP_W-1:0]    word
);
  for (genvar g = 0; g < SEQ_RATE; g++) begin : g_word
    logic [UOP_W-1:0] w;
    always_comb begin
      w = '0;
      w[UOP_W-1 -: 6] = ROM_TAG;
      w[OPC_W+CNT_W-1:CNT_W] = opcode;
      w[CNT_W-1:0] = baseStep + CNT_W'(g);
    end
    assign word[g] = w;
  end
endmodule

// File: rtl/uop_steer_ctrl.sv
module uop_steer_ctrl
  import uop_steer_pkg::*;
#(
  parameter int QDEPTH   = 6,
  parameter int MAX_CPLX = 4,
  parameter int SEQ_RATE = 4,
  parameter int QC_W     = $clog2(QDEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic [LANES-1:0]            inValid,
  input  logic [LANES-1:0][CNT_W-1:0] inCount,
  input  logic [QC_W-1:0]             qCount,
  output logic [LANES-1:0]            inReady,
  output steerStrobe_t                st
);
  logic             seqActive;
  logic [CNT_W-1:0] seqRemain;
  logic [CNT_W-1:0] seqStep;
  logic [CNT_W-1:0] seqChunk;
  int               freeInt;
  int               groupTotal;
  logic [LANES-1:0] groupMask;
  logic             chainOk;

  always_comb begin
    st         = '0;
    st.doFlush = flush;
    freeInt    = QDEPTH - int'(qCount);
    seqChunk   = '0;
    groupTotal = 0;
    groupMask  = '0;
    chainOk    = 1'b1;
    if (!flush) begin
      if (seqActive) begin
        seqChunk = (int'(seqRemain) < SEQ_RATE) ? seqRemain : CNT_W'(SEQ_RATE);
        if (freeInt >= int'(seqChunk)) begin
          st.seqEmit = 1'b1;
          st.pushCnt = PUSH_W'(seqChunk);
          st.seqStep = seqStep;
        end
      end else if (inValid[0]) begin
        if (int'(inCount[0]) > MAX_CPLX) begin
          st.take[0]  = 1'b1;
          st.seqLatch = 1'b1;
        end else begin
          groupTotal   = int'(inCount[0]);
          groupMask[0] = 1'b1;
          for (int i = 1; i < LANES; i++) begin
            if (chainOk && inValid[i] && inCount[i] == CNT_W'(1)) begin
              groupMask[i] = 1'b1;
              groupTotal   = groupTotal + 1;
            end else begin
              chainOk = 1'b0;
            end
          end
          if (freeInt >= groupTotal) begin
            st.take    = groupMask;
            st.pushCnt = PUSH_W'(groupTotal);
          end
        end
      end
    end
  end

  assign inReady = st.take;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqActive <= 1'b0;
      seqRemain <= '0;
      seqStep   <= '0;
    end else if (flush) begin
      seqActive <= 1'b0;
    end else if (st.seqLatch) begin
      seqActive <= 1'b1;
      seqRemain <= inCount[0];
      seqStep   <= '0;
    end else if (st.seqEmit) begin
      seqRemain <= seqRemain - seqChunk;
      seqStep   <= seqStep + seqChunk;
      if (seqRemain == seqChunk) seqActive <= 1'b0;
    end
  end

  // R6
  seq_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqActive |-> inReady == '0);

  // R6
  seq_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.seqLatch && !flush) |=> seqActive);

  // R10
  flush_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !seqActive);

  // R2
  count_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid[0] |-> inCount[0] != '0);

  for (genvar i = 1; i < LANES; i++) begin : g_lane_chk
    // R3
    simple_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
      inReady[i] |-> (inCount[i] == CNT_W'(1) && inReady[i-1] && int'(inCount[0]) <= MAX_CPLX));
  end
endmodule

// File: rtl/uop_steer_dpath.sv
module uop_steer_dpath
  import uop_steer_pkg::*;
#(
  parameter int UOP_W    = 118,
  parameter int OPC_W    = 8,
  parameter int QDEPTH   = 6,
  parameter int MAX_CPLX = 4,
  parameter int SEQ_RATE = 4,
  parameter int DRAIN    = 3,
  parameter int QC_W     = $clog2(QDEPTH + 1)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  steerStrobe_t                       st,
  input  logic [CNT_W-1:0]                   headCount,
  input  logic [OPC_W-1:0]                   headOpcode,
  input  logic [MAX_CPLX-1:0][UOP_W-1:0]     headPayload,
  input  logic [LANES-2:0][UOP_W-1:0]        tailPayload,
  input  logic [DRAIN-1:0]                   outReady,
  output logic [DRAIN-1:0]                   outValid,
  output logic [DRAIN-1:0][UOP_W-1:0]        outUop,
  output logic [QC_W-1:0]                    qCount
);
  logic [QDEPTH-1:0][UOP_W-1:0]   mem;
  logic [QDEPTH-1:0][UOP_W-1:0]   nextMem;
  logic [QDEPTH-1:0][UOP_W-1:0]   pushVec;
  logic [SEQ_RATE-1:0][UOP_W-1:0] romWord;
  logic [QC_W-1:0]                count;
  logic [OPC_W-1:0]               seqOpc;
  int                             pIdx;
  int                             popN;
  int                             keep;
  logic                           popChain;

  uop_seq_rom #(.UOP_W(UOP_W), .OPC_W(OPC_W), .SEQ_RATE(SEQ_RATE)) rom_i (
    .opcode  (seqOpc),
    .baseStep(st.seqStep),
    .word    (romWord)
  );

  always_comb begin
    pushVec = '0;
    pIdx    = 0;
    if (st.seqEmit) begin
      for (int k = 0; k < SEQ_RATE; k++) begin
        if (k < QDEPTH) pushVec[k] = romWord[k];
      end
    end else begin
      if (st.take[0]) begin
        for (int k = 0; k < MAX_CPLX; k++) begin
          if (k < int'(headCount) && pIdx < QDEPTH) begin
            pushVec[pIdx] = headPayload[k];
            pIdx = pIdx + 1;
          end
        end
      end
      for (int i = 0; i < LANES - 1; i++) begin
        if (st.take[i+1] && pIdx < QDEPTH) begin
          pushVec[pIdx] = tailPayload[i];
          pIdx = pIdx + 1;
        end
      end
    end
  end

  for (genvar i = 0; i < DRAIN; i++) begin : g_out
    assign outValid[i] = (i < int'(count));
    assign outUop[i]   = mem[i];
  end

  always_comb begin
    popN     = 0;
    popChain = 1'b1;
    for (int i = 0; i < DRAIN; i++) begin
      if (popChain && outValid[i] && outReady[i]) popN = popN + 1;
      else popChain = 1'b0;
    end
  end

  always_comb begin
    keep = int'(count) - popN;
    for (int j = 0; j < QDEPTH; j++) begin
      nextMem[j] = mem[j];
      if (j < keep) begin
        if (j + popN < QDEPTH) nextMem[j] = mem[j+popN];
      end else if (j - keep < int'(st.pushCnt)) begin
        nextMem[j] = pushVec[j-keep];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      mem    <= '0;
      seqOpc <= '0;
    end else begin
      mem <= nextMem;
      if (st.seqLatch) seqOpc <= headOpcode;
      if (st.doFlush) count <= '0;
      else count <= QC_W'(keep + int'(st.pushCnt));
    end
  end

  assign qCount = count;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= QDEPTH);

  // R5
  push_fit_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(st.pushCnt) <= QDEPTH - int'(count));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.doFlush |=> count == '0);

  // R8
  oldest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid[0] && !outReady[0] && !st.doFlush) |=> (outValid[0] && $stable(outUop[0])));
endmodule

// File: rtl/uop_steer_top.sv
module uop_steer_top
  import uop_steer_pkg::*;
#(
  parameter int UOP_W    = 118,
  parameter int OPC_W    = 8,
  parameter int QDEPTH   = 6,
  parameter int MAX_CPLX = 4,
  parameter int SEQ_RATE = 4,
  parameter int DRAIN    = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           flush,
  input  logic [LANES-1:0]               inValid,
  output logic [LANES-1:0]               inReady,
  input  logic [LANES-1:0][CNT_W-1:0]    inCount,
  input  logic [OPC_W-1:0]               inOpcode,
  input  logic [MAX_CPLX-1:0][UOP_W-1:0] headPayload,
  input  logic [LANES-2:0][UOP_W-1:0]    tailPayload,
  output logic [DRAIN-1:0]               outValid,
  input  logic [DRAIN-1:0]               outReady,
  output logic [DRAIN-1:0][UOP_W-1:0]    outUop
);
  localparam int QC_W = $clog2(QDEPTH + 1);

  steerStrobe_t    st;
  logic [QC_W-1:0] qCount;

  uop_steer_ctrl #(.QDEPTH(QDEPTH), .MAX_CPLX(MAX_CPLX), .SEQ_RATE(SEQ_RATE), .QC_W(QC_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (flush),
    .inValid(inValid),
    .inCount(inCount),
    .qCount (qCount),
    .inReady(inReady),
    .st     (st)
  );

  uop_steer_dpath #(.UOP_W(UOP_W), .OPC_W(OPC_W), .QDEPTH(QDEPTH), .MAX_CPLX(MAX_CPLX),
                    .SEQ_RATE(SEQ_RATE), .DRAIN(DRAIN), .QC_W(QC_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .headCount  (inCount[0]),
    .headOpcode (inOpcode),
    .headPayload(headPayload),
    .tailPayload(tailPayload),
    .outReady   (outReady),
    .outValid   (outValid),
    .outUop     (outUop),
    .qCount     (qCount)
  );
endmodule

// File: tb/uop_steer_tb.sv
`timescale 1ns/1ps
module uop_steer_top_tb_top;
  localparam int UW = 118;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 flush = 1'b0;
  logic [2:0]           inValid = '0;
  logic [2:0]           inReady;
  logic [2:0][3:0]      inCount = '0;
  logic [7:0]           inOpcode = '0;
  logic [3:0][UW-1:0]   headPayload = '0;
  logic [1:0][UW-1:0]   tailPayload = '0;
  logic [2:0]           outValid;
  logic [2:0]           outReady = '0;
  logic [2:0][UW-1:0]   outUop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  uop_steer_top dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inReady(inReady),
    .inCount(inCount), .inOpcode(inOpcode), .headPayload(headPayload),
    .tailPayload(tailPayload), .outValid(outValid), .outReady(outReady), .outUop(outUop)
  );

  function automatic logic [UW-1:0] pay(int v);
    return UW'(v) ^ (UW'(1) << 100);
  endfunction

  function automatic logic [UW-1:0] romW(logic [7:0] op, int s);
    logic [UW-1:0] r;
    r = '0;
    r[117:112] = 6'b101101;
    r[11:4] = op;
    r[3:0] = 4'(s);
    return r;
  endfunction

  task automatic chk(string req, string what, logic [UW-1:0] act, logic [UW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    inValid = '0; inCount = '0; inOpcode = '0; headPayload = '0; tailPayload = '0;
  endtask

  task automatic setHead(int cnt, int base, logic [7:0] op);
    inValid[0] = 1'b1; inCount[0] = 4'(cnt); inOpcode = op;
    for (int k = 0; k < 4; k++) headPayload[k] = pay(base + k);
  endtask

  task automatic setTail(int lane, int cnt, int v);
    inValid[lane] = 1'b1; inCount[lane] = 4'(cnt); tailPayload[lane-1] = pay(v);
  endtask

  task automatic drain();
    outReady = 3'b111;
    @(negedge clk);
    outReady = 3'b000;
  endtask

  task automatic tReset();
    #1;
    chk("R1", "outValid after reset", UW'(outValid), UW'(3'b000));
    chk("R1", "inReady idle", UW'(inReady), UW'(3'b000));
    @(negedge clk);
  endtask

  task automatic tSingles();
    setHead(1, 100, 8'h00); setTail(1, 1, 200); setTail(2, 1, 300);
    #1 chk("R3", "three singles taken", UW'(inReady), UW'(3'b111));
    @(negedge clk); clearIn();
    #1 chk("R8", "three entries valid", UW'(outValid), UW'(3'b111));
    chk("R8", "order lane0", outUop[0], pay(100));
    chk("R8", "order lane1", outUop[1], pay(200));
    chk("R8", "order lane2", outUop[2], pay(300));
    drain();
    #1 chk("R8", "drained to empty", UW'(outValid), UW'(3'b000));
  endtask

  task automatic tComplex();
    setHead(3, 400, 8'h00); setTail(1, 1, 500); setTail(2, 2, 600);
    #1 chk("R4", "complex plus one single", UW'(inReady), UW'(3'b011));
    @(negedge clk); clearIn();
    #1 chk("R4", "complex uop0", outUop[0], pay(400));
    chk("R4", "complex uop1", outUop[1], pay(401));
    chk("R4", "complex uop2", outUop[2], pay(402));
    drain();
    #1 chk("R4", "single after complex valid", UW'(outValid), UW'(3'b001));
    chk("R4", "single after complex", outUop[0], pay(500));
    drain();
  endtask

  task automatic tMultiLane1();
    setHead(1, 700, 8'h00); setTail(1, 2, 710); setTail(2, 1, 720);
    #1 chk("R3", "multi-uop in lane1 refused", UW'(inReady), UW'(3'b001));
    @(negedge clk); clearIn();
    drain();
  endtask

  task automatic tStall();
    setHead(4, 800, 8'h00);
    @(negedge clk); clearIn();
    setHead(3, 850, 8'h00);
    #1 chk("R5", "no room for 3 with 2 free", UW'(inReady), UW'(3'b000));
    outReady = 3'b001;
    @(negedge clk); outReady = 3'b000;
    #1 chk("R5", "taken once 3 free", UW'(inReady), UW'(3'b001));
    @(negedge clk); clearIn();
    #1 chk("R5", "queue full", UW'(outValid), UW'(3'b111));
    chk("R5", "older entry first", outUop[0], pay(801));
    drain();
    #1 chk("R5", "group head", outUop[0], pay(850));
    chk("R5", "group tail", outUop[2], pay(852));
    drain();
  endtask

  task automatic tSeq();
    logic [UW-1:0] got[$];
    setHead(10, 0, 8'h5A); setTail(1, 1, 900);
    #1 chk("R6", "long taken alone", UW'(inReady), UW'(3'b001));
    @(negedge clk);
    clearIn(); setHead(1, 900, 8'h00);
    outReady = 3'b111;
    for (int cyc = 0; cyc < 12; cyc++) begin
      #1;
      if (cyc < 4) chk("R6", $sformatf("window blocked cycle %0d", cyc), UW'(inReady), UW'(3'b000));
      if (cyc == 1) chk("R6", "first chunk of 4", UW'(outValid), UW'(3'b111));
      for (int i = 0; i < 3; i++) if (outValid[i]) got.push_back(outUop[i]);
      if (inReady[0]) begin
        @(negedge clk); clearIn();
      end else begin
        @(negedge clk);
      end
    end
    outReady = 3'b000;
    chk("R6", "uop total", UW'(got.size()), UW'(11));
    for (int s = 0; s < 10; s++)
      if (s < got.size()) chk("R7", $sformatf("rom step %0d", s), got[s], romW(8'h5A, s));
    if (got.size() > 10) chk("R6", "single after sequence", got[10], pay(900));
  endtask

  task automatic tPeak();
    setHead(4, 1000, 8'h00); setTail(1, 1, 1100); setTail(2, 1, 1200);
    #1 chk("R9", "six-uop group", UW'(inReady), UW'(3'b111));
    @(negedge clk); clearIn(); setHead(1, 1300, 8'h00);
    #1 chk("R9", "full queue refuses", UW'(inReady), UW'(3'b000));
    chk("R9", "full valid", UW'(outValid), UW'(3'b111));
    clearIn();
    drain();
    #1 chk("R9", "entry 3", outUop[0], pay(1003));
    chk("R9", "entry 4", outUop[1], pay(1100));
    chk("R9", "entry 5", outUop[2], pay(1200));
    drain();
  endtask

  task automatic tFlush();
    setHead(2, 1400, 8'h00);
    @(negedge clk); clearIn(); setHead(12, 0, 8'h33);
    @(negedge clk); clearIn();
    @(negedge clk);
    flush = 1'b1; setHead(1, 1500, 8'h00);
    #1 chk("R10", "no take during flush", UW'(inReady), UW'(3'b000));
    @(negedge clk); flush = 1'b0;
    #1 chk("R10", "queue empty after flush", UW'(outValid), UW'(3'b000));
    chk("R10", "sequencer aborted", UW'(inReady), UW'(3'b001));
    @(negedge clk); clearIn();
    #1 chk("R10", "only new uop", UW'(outValid), UW'(3'b001));
    chk("R10", "new uop value", outUop[0], pay(1500));
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tSingles();
    tComplex();
    tMultiLane1();
    tStall();
    tSeq();
    tPeak();
    tFlush();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule